// File: doc/BRIEF.md
# Line-Boundary Access Splitter

This block sits between a load/store requester and a memory port that only accepts accesses lying inside one cache line. It takes one request at a time: an address, a size code, a read/write flag and, for stores, a data word. It works out whether the bytes touched run past the end of the line that holds the first byte. If they do not, it forwards the access unchanged as a single sub-request. If they do, it issues two sub-requests, the low piece first and the high piece second. For a load, it merges the two returned pieces into one little-endian word before it reports a single completion to the requester.

The split point is the address of the last byte rounded down to a line boundary. The access is split only when that point lies strictly above the request address. The low piece runs from the request address up to the split point. The high piece starts at the split point and holds the remaining bytes. Store data is cut at the same byte offset, and each piece's bytes are placed from byte lane 0 of the sub-request data. The line size must be a power of two no smaller than the data word, so that an access never touches more than two lines.

Top module: `line_split_unit`

## Requirements
- R1: The size code maps to a byte count: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. An access that stays within one line is issued as exactly one sub-request with the request address and that byte count.
- R2: The split point is floor((addr + bytes - 1) / LINE_BYTES) * LINE_BYTES. The access is split into two sub-requests exactly when the split point is greater than addr.
- R3: For a split access, the first sub-request carries addr and a byte count of (split point - addr). It is the first one issued.
- R4: For a split access, the second sub-request carries the split point and a byte count of (addr + bytes - split point). It is presented only after the first has been accepted.
- R5: The store data of a sub-request holds its own bytes from byte lane 0 upward, and every lane above its byte count is zero. The low piece takes request bytes 0 to n0-1, and the high piece takes request bytes n0 upward, where n0 is the low piece's byte count.
- R6: Load result byte i equals byte i of the low piece's response for i < n0, and byte (i - n0) of the high piece's response for n0 <= i < bytes. All higher bytes are zero. Response lanes at or above a piece's byte count are ignored. For a store, the result data is zero.
- R7: The completion is raised only after one response has come back for every sub-request issued. It reports the original address, the original byte count and the read/write flag.
- R8: req_ready is high only when no access is in flight. It drops once a request is accepted and rises again only after the completion handshake.
- R9: While sub_valid is high and sub_ready is low, the sub-request fields hold steady. While rsp_valid is high and rsp_ready is low, the completion fields hold steady.
- R10: After reset, req_ready is 1 and both sub_valid and rsp_valid are 0.
- R11: No sub-request reaches past the end of the line that holds its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code, byte count = 1 << code |
| req_wdata | input | DATA_W | Store data, byte 0 at lane 0 |
| rsp_valid | output | 1 | Completion present |
| rsp_ready | input | 1 | Requester takes the completion |
| rsp_write | output | 1 | Read/write flag of the completed access |
| rsp_addr | output | ADDR_W | Original address of the completed access |
| rsp_nbytes | output | NB_W | Original byte count |
| rsp_rdata | output | DATA_W | Merged load data, zero for stores |
| sub_valid | output | 1 | Sub-request present |
| sub_ready | input | 1 | Memory port takes the sub-request |
| sub_write | output | 1 | Read/write flag of the sub-request |
| sub_addr | output | ADDR_W | Sub-request byte address |
| sub_nbytes | output | NB_W | Sub-request byte count |
| sub_wdata | output | DATA_W | Sub-request store bytes from lane 0 |
| sub_rsp_valid | input | 1 | One sub-request response, always taken |
| sub_rsp_rdata | input | DATA_W | Response bytes from lane 0 |

## Verification
The assertions take for granted that the memory port returns exactly one response per accepted sub-request. They also assume those responses come back in issue order and never before the matching sub-request was accepted. A response-count property flags any surplus. They further assume that addr plus byte count does not wrap the address space. The bench stays within these limits: it sends a response only after each sub-request handshake, one per piece, and keeps the top address bit clear. Its random stalls on sub_ready and rsp_ready drive both hold-steady properties.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_WAIT,
    ST_DONE
  } split_state_e;

  // byte count for a power-of-two size code
  function automatic int bytes_of_code(input logic [1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/lsplit_plan.sv
module lsplit_plan #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int LINE_BYTES = 16,
  parameter int NB_W       = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NB_W-1:0]         nbytes,
  input  logic [8*DATA_BYTES-1:0] wdata,
  output logic                    is_split,
  output logic [ADDR_W-1:0]       addr_hi,
  output logic [NB_W-1:0]         n_lo,
  output logic [NB_W-1:0]         n_hi,
  output logic [8*DATA_BYTES-1:0] wdata_lo,
  output logic [8*DATA_BYTES-1:0] wdata_hi
);
  localparam int DW = 8 * DATA_BYTES;
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] line_floor(input logic [ADDR_W-1:0] a);
    return a & ~LINE_MASK;
  endfunction

  // keep the lowest n byte lanes, clear the rest
  function automatic logic [DW-1:0] keep_bytes(input logic [DW-1:0] d, input int n);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (i < n) r[8*i +: 8] = d[8*i +: 8];
    end
    return r;
  endfunction

  logic [ADDR_W-1:0] last_byte;
  logic [ADDR_W-1:0] lo_span;

  always_comb begin
    last_byte = addr + ADDR_W'(nbytes) - ADDR_W'(1);
    addr_hi   = line_floor(last_byte);
    is_split  = addr_hi > addr;
    lo_span   = addr_hi - addr;
    n_lo      = is_split ? NB_W'(lo_span) : nbytes;
    n_hi      = is_split ? (nbytes - n_lo) : '0;
    wdata_lo  = keep_bytes(wdata, int'(n_lo));
    wdata_hi  = keep_bytes(wdata >> (8 * int'(n_lo)), int'(n_hi));
  end

endmodule

// File: rtl/lsplit_ctrl.sv
module lsplit_ctrl
  import lsplit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic sub_ready,
  input  logic rsp_ready,
  input  logic is_split,
  input  logic all_back,
  output logic req_ready,
  output logic accept,
  output logic sub_valid,
  output logic sub_sel,
  output logic rsp_valid
);
  split_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_LO;
      ST_LO:   if (sub_ready) st_d = is_split ? ST_HI : ST_WAIT;
      ST_HI:   if (sub_ready) st_d = ST_WAIT;
      ST_WAIT: if (all_back)  st_d = ST_DONE;
      ST_DONE: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign sub_valid = (st_q == ST_LO) || (st_q == ST_HI);
  assign sub_sel   = (st_q == ST_HI);
  assign rsp_valid = (st_q == ST_DONE);

  // R8: never ready for a new request while a completion is pending
  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R7: completion rises only once every response has returned
  assert_done_after_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(all_back));

  // R3: the high piece follows an accepted low piece
  assert_hi_after_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_sel) |-> $past(sub_valid && sub_ready));

  // R4: a high piece exists only for a crossing access
  assert_hi_only_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_sel) |-> is_split);

endmodule

// File: rtl/lsplit_merge.sv
module lsplit_merge #(
  parameter int DATA_BYTES = 8,
  parameter int NB_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_valid,
  input  logic                    capture_en,
  input  logic [8*DATA_BYTES-1:0] in_data,
  input  logic [NB_W-1:0]         n_lo,
  input  logic [NB_W-1:0]         n_hi,
  input  logic [1:0]              need,
  output logic [1:0]              rcnt,
  output logic [8*DATA_BYTES-1:0] buf_q
);
  localparam int DW = 8 * DATA_BYTES;

  logic [NB_W-1:0] cur_off;
  logic [NB_W-1:0] cur_n;
  logic [DW-1:0]   aligned;

  function automatic logic lane_hit(input int lane, input int off, input int n);
    return (lane >= off) && (lane < off + n);
  endfunction

  // responses arrive in issue order: the first fills from lane 0, the second after it
  assign cur_off = (rcnt == 2'd0) ? '0 : n_lo;
  assign cur_n   = (rcnt == 2'd0) ? n_lo : n_hi;
  assign aligned = in_data << (8 * int'(cur_off));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rcnt <= 2'd0;
    else if (clear)    rcnt <= 2'd0;
    else if (in_valid) rcnt <= rcnt + 2'd1;
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
    logic       hit;
    logic [7:0] lane_q;
    assign hit = in_valid && capture_en && lane_hit(b, int'(cur_off), int'(cur_n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (clear) lane_q <= '0;
      else if (hit)   lane_q <= aligned[8*b +: 8];
    end
    assign buf_q[8*b +: 8] = lane_q;
  end

  // R7: no more responses than sub-requests of the current access
  assert_no_excess_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (rcnt < need));

endmodule

// File: rtl/line_split_unit.sv
module line_split_unit #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 16,
  parameter int NB_W       = $clog2(DATA_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_write,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [NB_W-1:0]   rsp_nbytes,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic              sub_write,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [NB_W-1:0]   sub_nbytes,
  output logic [DATA_W-1:0] sub_wdata,
  input  logic              sub_rsp_valid,
  input  logic [DATA_W-1:0] sub_rsp_rdata
);
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  // latched request
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [NB_W-1:0]   lat_nbytes;
  logic [DATA_W-1:0] lat_wdata;

  // named internal events
  logic              accept;
  logic              sub_sel;
  logic              is_split;
  logic              all_back;
  logic [1:0]        need;
  logic [1:0]        rcnt;
  logic [ADDR_W-1:0] addr_hi;
  logic [NB_W-1:0]   n_lo, n_hi;
  logic [DATA_W-1:0] wdata_lo, wdata_hi;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write  <= 1'b0;
      lat_addr   <= '0;
      lat_nbytes <= '0;
      lat_wdata  <= '0;
    end else if (accept) begin
      lat_write  <= req_write;
      lat_addr   <= req_addr;
      lat_nbytes <= NB_W'(lsplit_pkg::bytes_of_code(req_size));
      lat_wdata  <= req_wdata;
    end
  end

  lsplit_plan #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LINE_BYTES(LINE_BYTES), .NB_W(NB_W)
  ) u_plan (
    .addr(lat_addr), .nbytes(lat_nbytes), .wdata(lat_wdata),
    .is_split(is_split), .addr_hi(addr_hi), .n_lo(n_lo), .n_hi(n_hi),
    .wdata_lo(wdata_lo), .wdata_hi(wdata_hi)
  );

  lsplit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sub_ready(sub_ready),
    .rsp_ready(rsp_ready), .is_split(is_split), .all_back(all_back),
    .req_ready(req_ready), .accept(accept), .sub_valid(sub_valid),
    .sub_sel(sub_sel), .rsp_valid(rsp_valid)
  );

  assign need     = is_split ? 2'd2 : 2'd1;
  assign all_back = (rcnt == need);

  lsplit_merge #(.DATA_BYTES(DATA_BYTES), .NB_W(NB_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .clear(accept), .in_valid(sub_rsp_valid),
    .capture_en(!lat_write), .in_data(sub_rsp_rdata), .n_lo(n_lo), .n_hi(n_hi),
    .need(need), .rcnt(rcnt), .buf_q(merged)
  );

  assign sub_write  = lat_write;
  assign sub_addr   = sub_sel ? addr_hi  : lat_addr;
  assign sub_nbytes = sub_sel ? n_hi     : n_lo;
  assign sub_wdata  = sub_sel ? wdata_hi : wdata_lo;

  assign rsp_write  = lat_write;
  assign rsp_addr   = lat_addr;
  assign rsp_nbytes = lat_nbytes;
  assign rsp_rdata  = merged;

  // R9: sub-request held while stalled
  assert_sub_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) &&
      $stable(sub_nbytes) && $stable(sub_wdata) && $stable(sub_write)));

  // R9: completion held while stalled
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) &&
      $stable(rsp_addr) && $stable(rsp_nbytes)));

  // R11: every piece stays inside one line and is non-empty
  assert_piece_in_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ((sub_nbytes != '0) &&
      (int'(sub_addr[OFF_W-1:0]) + int'(sub_nbytes) <= LINE_BYTES)));

endmodule

// File: tb/line_split_unit_tb.sv
module line_split_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int LINE   = 16;
  localparam int NB_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic rsp_ready = 1'b0, sub_ready = 1'b0, sub_rsp_valid = 1'b0;
  logic [DATA_W-1:0] sub_rsp_rdata = '0;
  logic req_ready, rsp_valid, rsp_write, sub_valid, sub_write;
  logic [ADDR_W-1:0] rsp_addr, sub_addr;
  logic [NB_W-1:0] rsp_nbytes, sub_nbytes;
  logic [DATA_W-1:0] rsp_rdata, sub_wdata;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_split_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_nbytes(rsp_nbytes),
    .rsp_rdata(rsp_rdata), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_write(sub_write), .sub_addr(sub_addr), .sub_nbytes(sub_nbytes),
    .sub_wdata(sub_wdata), .sub_rsp_valid(sub_rsp_valid),
    .sub_rsp_rdata(sub_rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory contents seen by the downstream model
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  // bytes that stay in the line of the first byte
  function automatic int first_len(input logic [31:0] a, input int n);
    int c = 0;
    for (int i = 0; i < n; i++)
      if (((longint'(a) + i) / LINE) == (longint'(a) / LINE)) c++;
    return c;
  endfunction

  function automatic logic [63:0] bytes_from(input logic [63:0] d, input int start, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(start+i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mem_reply(input logic [31:0] a, input int n);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (i < n) ? mem_byte(a + 32'(i)) : 8'hEE;
    return r;
  endfunction

  task automatic do_access(input bit wr, input logic [31:0] addr, input logic [1:0] code,
                           input logic [63:0] wd);
    int n = 1 << code;
    int n0 = first_len(addr, n);
    bit split = (n0 < n);
    int np = split ? 2 : 1;
    logic [63:0] exp_rd = '0;
    for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mem_byte(addr + 32'(i));
    if (wr) exp_rd = '0;

    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = code; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);

    for (int k = 0; k < np; k++) begin
      logic [31:0] pa;
      int pn;
      logic [63:0] pw;
      logic [31:0] s_addr;
      logic [NB_W-1:0] s_n;
      logic [63:0] s_w;
      int guard = 0;
      int stall;
      pa = (k == 0) ? addr : addr + 32'(n0);
      pn = (k == 0) ? n0 : n - n0;
      pw = (k == 0) ? bytes_from(wd, 0, pn) : bytes_from(wd, n0, pn);
      while (sub_valid !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
      s_addr = sub_addr; s_n = sub_nbytes; s_w = sub_wdata;
      stall = $urandom % 3;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(sub_valid === 1'b1 && sub_addr === s_addr && sub_nbytes === s_n &&
            sub_wdata === s_w, "R9 sub hold", sub_addr, s_addr);
        chk(req_ready === 1'b0, "R8 no accept mid-access", 64'(req_ready), 64'd0);
      end
      chk(sub_valid === 1'b1, "R3 piece presented", 64'(sub_valid), 64'd1);
      chk(sub_addr === pa, (k == 0) ? "R3 first addr" : "R4 second addr", sub_addr, pa);
      chk(int'(sub_nbytes) == pn,
          split ? ((k == 0) ? "R3 first size" : "R4 second size") : "R1 single size",
          64'(sub_nbytes), 64'(pn));
      chk(sub_write === wr, "R1 write flag", 64'(sub_write), 64'(wr));
      if (wr) chk(sub_wdata === pw, "R5 store slice", sub_wdata, pw);
      chk((int'(sub_addr) % LINE) + int'(sub_nbytes) <= LINE, "R11 piece in line",
          64'(sub_addr), 64'(pa));
      sub_ready = 1'b1;
      @(negedge clk);
      sub_ready = 1'b0;
      if (k == 0)
        chk(sub_valid === split, "R2 second piece iff crossing", 64'(sub_valid), 64'(split));
      repeat ($urandom % 3) @(negedge clk);
      sub_rsp_valid = 1'b1; sub_rsp_rdata = mem_reply(pa, pn);
      @(negedge clk);
      sub_rsp_valid = 1'b0; sub_rsp_rdata = '0;
      chk(rsp_valid === 1'b0, "R7 no completion yet", 64'(rsp_valid), 64'd0);
    end

    begin
      int guard = 0;
      int stall = $urandom % 3;
      logic [63:0] s_rd;
      while (rsp_valid !== 1'b1 && guard < 50) begin @(negedge clk); guard++; end
      s_rd = rsp_rdata;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(rsp_valid === 1'b1 && rsp_rdata === s_rd, "R9 rsp hold", rsp_rdata, s_rd);
      end
      chk(rsp_valid === 1'b1, "R7 completion raised", 64'(rsp_valid), 64'd1);
      chk(rsp_addr === addr, "R7 original addr", rsp_addr, addr);
      chk(int'(rsp_nbytes) == n, "R1 R7 original size", 64'(rsp_nbytes), 64'(n));
      chk(rsp_write === wr, "R7 write flag", 64'(rsp_write), 64'(wr));
      chk(rsp_rdata === exp_rd, wr ? "R6 store data zero" : "R6 merged load",
          rsp_rdata, exp_rd);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R8 ready after completion",
          64'(req_ready), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && sub_valid === 1'b0 && rsp_valid === 1'b0,
        "R10 in reset", {req_ready, sub_valid, rsp_valid}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && sub_valid === 1'b0 && rsp_valid === 1'b0,
        "R10 after reset", {req_ready, sub_valid, rsp_valid}, 64'b100);

    // directed corners
    do_access(1'b0, 32'h0000_100F, 2'd3, '0);                     // 1 + 7
    do_access(1'b0, 32'h0000_1008, 2'd3, '0);                     // ends on line end
    do_access(1'b0, 32'h0000_1009, 2'd3, '0);                     // 7 + 1
    do_access(1'b0, 32'h0000_200F, 2'd0, '0);                     // one byte never splits
    do_access(1'b0, 32'h0000_300F, 2'd1, '0);                     // 1 + 1
    do_access(1'b1, 32'h0000_400D, 2'd3, 64'h8877_6655_4433_2211); // store 3 + 5
    do_access(1'b1, 32'h0000_500E, 2'd2, 64'hDEAD_BEEF_CAFE_F00D); // store 2 + 2
    do_access(1'b0, 32'h0000_6000, 2'd3, '0);                     // aligned
    do_access(1'b1, 32'h0000_700C, 2'd2, 64'h0102_0304_0506_0708); // exact fit

    for (int t = 0; t < 300; t++) begin
      logic [31:0] a = $urandom & 32'h7FFF_FFFF;
      logic [1:0] c = 2'($urandom % 4);
      logic w = 1'($urandom % 2);
      logic [63:0] d = {$urandom, $urandom};
      do_access(w, a, c, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule